// File: doc/BRIEF.md
# Banked Control Register File

This block holds the processor's control registers and serves them by a small index through one read/write port: the status byte with its backup byte, a second-level backup status byte, the condition bit, interrupt-mode and user-mode stack-pointer shadows, two backup program counters and two general-purpose 32-bit slots. It also holds the live stack pointer that the general-register file sees as its SP. A write that flips the stack-mode bit swaps the live stack pointer with the matching shadow in the same clock edge.

A second, byte-wide port reads and writes the status byte and condition bit directly, without touching the stack banks. Reads on both ports are combinational from the current index. All writes take effect at the rising clock edge. Index values come from top-level parameters: status 0, condition 1, interrupt stack 2, user stack 3, slots 4 and 5, backup PC 6, second-level backup status 7, second-level backup PC 8.

Top module: `ctl_reg_bank`

## Requirements
- R1: A synchronous reset clears every register, so every readable index, the status byte output and the live stack pointer read zero.
- R2: Reading index 0 returns bits 31:16 zero, bits 15:8 the backup byte ANDed with 0xC1, bits 7:6 status bits 7:6, bits 5:1 zero and bit 0 the condition bit.
- R3: Writing index 0 loads the backup byte from data bits 15:8, the status byte from bits 7:0 and the condition bit from bit 0.
- R4: Bit 7 of status is stack mode. A write to index 0 that moves it from 1 to 0 stores the live SP into the user shadow and loads the interrupt shadow into live SP; a move from 0 to 1 stores live SP into the interrupt shadow and loads the user shadow into live SP.
- R5: The SP write port loads live SP at the edge, except when a swap (R4) or a control-register write that reaches live SP happens in the same cycle; that write wins.
- R6: Index 2 reaches live SP when stack mode is 0 and its shadow otherwise; index 3 reaches live SP when stack mode is 1 and its shadow otherwise.
- R7: Index 1 reads the condition bit alone in bit 0; a write to it changes only the condition bit, from data bit 0.
- R8: Index 7 stores the low 8 data bits and reads back that byte ANDed with 0xC1.
- R9: Indices 6 and 8 store all 32 bits and read back with bit 0 forced to zero.
- R10: Indices 4 and 5 are independent plain 32-bit storage.
- R11: Any other index reads zero, and a write to it changes no register.
- R12: The byte port reads status bits 7:1 with the condition bit in bit 0; a byte write loads status and sets the condition bit from bit 0, and never swaps the stack banks.
- R13: When a control-register write to index 0 or 1 and a byte-port write fall in the same cycle, the control-register write sets the fields it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| crIndex | input | 4 | Control register index for read and write |
| crWrEn | input | 1 | Control register write strobe |
| crWrData | input | 32 | Control register write data |
| crRdData | output | 32 | Control register read data for crIndex |
| statWrEn | input | 1 | Byte-wide status write strobe |
| statWrData | input | 8 | Byte-wide status write data |
| statRdData | output | 8 | Byte-wide status read data |
| spWrEn | input | 1 | General-register file write to SP |
| spWrData | input | 32 | Value written to SP by the register file |
| spOut | output | 32 | Live stack pointer |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 4-bit index and the default index map, so indices 9 to 15 are free and the unused-index rule can be exercised at both ends of that range. With those values the stack-pointer shadows, both swap directions and the collisions between the SP port, the byte port and control-register writes all sit within a few dozen cycles of reset.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 4;
  localparam int SCR_N    = 2;
  localparam logic [7:0] BK_MASK  = 8'hC1;
  localparam logic [7:0] ST_MASK  = 8'hC0;
  localparam int SM_BIT   = 7;

  typedef enum logic [3:0] {
    RD_ZERO, RD_STATUS, RD_COND, RD_ISP, RD_USP,
    RD_SCR, RD_BPC, RD_BBPSW, RD_BBPC
  } rdSel_t;

  typedef struct packed {
    logic             status;
    logic             cond;
    logic             isp;
    logic             usp;
    logic [SCR_N-1:0] scr;
    logic             bpc;
    logic             bbpsw;
    logic             bbpc;
    logic             statByte;
  } crStrobe_t;
endpackage

// File: rtl/ctl_reg_ctrl.sv
module ctl_reg_ctrl
  import ctl_reg_pkg::*;
#(
  parameter int IX_STATUS = 0,
  parameter int IX_COND   = 1,
  parameter int IX_ISP    = 2,
  parameter int IX_USP    = 3,
  parameter int IX_SCR    = 4,
  parameter int IX_BPC    = 6,
  parameter int IX_BBPSW  = 7,
  parameter int IX_BBPC   = 8
) (
  input  logic [IDX_W-1:0] crIndex,
  input  logic             crWrEn,
  input  logic             statWrEn,
  output crStrobe_t        stb,
  output rdSel_t           rdSel,
  output logic [$clog2(SCR_N)-1:0] scrIdx
);
  logic [SCR_N-1:0] scrHit;

  for (genvar g = 0; g < SCR_N; g++) begin : g_scrHit
    assign scrHit[g] = (crIndex == IDX_W'(IX_SCR + g));
  end

  always_comb begin
    scrIdx = '0;
    for (int k = 0; k < SCR_N; k++) begin
      if (scrHit[k]) scrIdx = k[$clog2(SCR_N)-1:0];
    end
  end

  always_comb begin
    stb          = '0;
    stb.status   = crWrEn && (crIndex == IDX_W'(IX_STATUS));
    stb.cond     = crWrEn && (crIndex == IDX_W'(IX_COND));
    stb.isp      = crWrEn && (crIndex == IDX_W'(IX_ISP));
    stb.usp      = crWrEn && (crIndex == IDX_W'(IX_USP));
    stb.scr      = crWrEn ? scrHit : '0;
    stb.bpc      = crWrEn && (crIndex == IDX_W'(IX_BPC));
    stb.bbpsw    = crWrEn && (crIndex == IDX_W'(IX_BBPSW));
    stb.bbpc     = crWrEn && (crIndex == IDX_W'(IX_BBPC));
    stb.statByte = statWrEn;
  end

  always_comb begin
    if      (crIndex == IDX_W'(IX_STATUS)) rdSel = RD_STATUS;
    else if (crIndex == IDX_W'(IX_COND))   rdSel = RD_COND;
    else if (crIndex == IDX_W'(IX_ISP))    rdSel = RD_ISP;
    else if (crIndex == IDX_W'(IX_USP))    rdSel = RD_USP;
    else if (|scrHit)                      rdSel = RD_SCR;
    else if (crIndex == IDX_W'(IX_BPC))    rdSel = RD_BPC;
    else if (crIndex == IDX_W'(IX_BBPSW))  rdSel = RD_BBPSW;
    else if (crIndex == IDX_W'(IX_BBPC))   rdSel = RD_BBPC;
    else                                   rdSel = RD_ZERO;
  end
endmodule

// File: rtl/ctl_reg_dp.sv
module ctl_reg_dp
  import ctl_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  crStrobe_t         stb,
  input  rdSel_t            rdSel,
  input  logic [$clog2(SCR_N)-1:0] scrIdx,
  input  logic [DATA_W-1:0] crWrData,
  input  logic [7:0]        statWrData,
  input  logic              spWrEn,
  input  logic [DATA_W-1:0] spWrData,
  output logic [DATA_W-1:0] crRdData,
  output logic [7:0]        statRdData,
  output logic [DATA_W-1:0] spOut
);
  logic [7:0]        status, bkStatus, bbStatus;
  logic              condBit;
  logic [DATA_W-1:0] liveSp, ispShadow, uspShadow, bpcReg, bbpcReg;
  logic [SCR_N-1:0][DATA_W-1:0] scrReg;

  logic stackMode, swapReq, crHitsLive;
  assign stackMode  = status[SM_BIT];
  assign swapReq    = stb.status && (crWrData[SM_BIT] != stackMode);
  assign crHitsLive = (stb.isp && !stackMode) || (stb.usp && stackMode);

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      bkStatus <= '0;
      condBit  <= 1'b0;
    end else begin
      if (stb.status) begin
        bkStatus <= crWrData[15:8];
        status   <= crWrData[7:0];
        condBit  <= crWrData[0];
      end else begin
        if (stb.statByte) status <= statWrData;
        if (stb.cond)          condBit <= crWrData[0];
        else if (stb.statByte) condBit <= statWrData[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      liveSp    <= '0;
      ispShadow <= '0;
      uspShadow <= '0;
    end else if (swapReq) begin
      if (stackMode) begin
        uspShadow <= liveSp;
        liveSp    <= ispShadow;
      end else begin
        ispShadow <= liveSp;
        liveSp    <= uspShadow;
      end
    end else begin
      if (crHitsLive)      liveSp <= crWrData;
      else if (spWrEn)     liveSp <= spWrData;
      if (stb.isp && stackMode)  ispShadow <= crWrData;
      if (stb.usp && !stackMode) uspShadow <= crWrData;
    end
  end

  for (genvar g = 0; g < SCR_N; g++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst)             scrReg[g] <= '0;
      else if (stb.scr[g]) scrReg[g] <= crWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bpcReg   <= '0;
      bbpcReg  <= '0;
      bbStatus <= '0;
    end else begin
      if (stb.bpc)   bpcReg   <= crWrData;
      if (stb.bbpc)  bbpcReg  <= crWrData;
      if (stb.bbpsw) bbStatus <= crWrData[7:0];
    end
  end

  always_comb begin
    crRdData = '0;
    unique case (rdSel)
      RD_STATUS: crRdData = DATA_W'({bkStatus & BK_MASK,
                                     (status & ST_MASK) | {7'b0, condBit}});
      RD_COND:   crRdData = DATA_W'(condBit);
      RD_ISP:    crRdData = stackMode ? ispShadow : liveSp;
      RD_USP:    crRdData = stackMode ? liveSp : uspShadow;
      RD_SCR:    crRdData = scrReg[scrIdx];
      RD_BPC:    crRdData = {bpcReg[DATA_W-1:1], 1'b0};
      RD_BBPSW:  crRdData = DATA_W'(bbStatus & BK_MASK);
      RD_BBPC:   crRdData = {bbpcReg[DATA_W-1:1], 1'b0};
      default:   crRdData = '0;
    endcase
  end

  assign statRdData = {status[7:1], condBit};
  assign spOut      = liveSp;
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
#(
  parameter int IX_STATUS = 0,
  parameter int IX_COND   = 1,
  parameter int IX_ISP    = 2,
  parameter int IX_USP    = 3,
  parameter int IX_SCR    = 4,
  parameter int IX_BPC    = 6,
  parameter int IX_BBPSW  = 7,
  parameter int IX_BBPC   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  crIndex,
  input  logic              crWrEn,
  input  logic [DATA_W-1:0] crWrData,
  output logic [DATA_W-1:0] crRdData,
  input  logic              statWrEn,
  input  logic [7:0]        statWrData,
  output logic [7:0]        statRdData,
  input  logic              spWrEn,
  input  logic [DATA_W-1:0] spWrData,
  output logic [DATA_W-1:0] spOut
);
  crStrobe_t stb;
  rdSel_t    rdSel;
  logic [$clog2(SCR_N)-1:0] scrIdx;

  ctl_reg_ctrl #(
    .IX_STATUS(IX_STATUS), .IX_COND(IX_COND), .IX_ISP(IX_ISP), .IX_USP(IX_USP),
    .IX_SCR(IX_SCR), .IX_BPC(IX_BPC), .IX_BBPSW(IX_BBPSW), .IX_BBPC(IX_BBPC)
  ) u_ctrl (
    .crIndex(crIndex), .crWrEn(crWrEn), .statWrEn(statWrEn),
    .stb(stb), .rdSel(rdSel), .scrIdx(scrIdx)
  );

  ctl_reg_dp u_dp (
    .clk(clk), .rst(rst), .stb(stb), .rdSel(rdSel), .scrIdx(scrIdx),
    .crWrData(crWrData), .statWrData(statWrData),
    .spWrEn(spWrEn), .spWrData(spWrData),
    .crRdData(crRdData), .statRdData(statRdData), .spOut(spOut)
  );
endmodule

// File: rtl/ctl_reg_bank_chk.sv
module ctl_reg_bank_chk
  import ctl_reg_pkg::*;
#(
  parameter int IX_STATUS = 0,
  parameter int IX_BPC    = 6,
  parameter int IX_BBPSW  = 7,
  parameter int IX_BBPC   = 8,
  parameter int IX_LAST   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  crIndex,
  input logic              crWrEn,
  input logic [DATA_W-1:0] crRdData,
  input logic [7:0]        statRdData,
  input logic              spWrEn,
  input logic [DATA_W-1:0] spWrData,
  input logic [DATA_W-1:0] spOut
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (spOut == '0 && statRdData == 8'h00));

  assert_status_shape_R2: assert property (@(posedge clk) disable iff (rst)
    crIndex == IDX_W'(IX_STATUS) |->
      (crRdData[DATA_W-1:16] == '0 && crRdData[5:1] == 5'b0 &&
       (crRdData[15:8] & ~BK_MASK) == 8'h00));

  assert_ports_agree_R12: assert property (@(posedge clk) disable iff (rst)
    crIndex == IDX_W'(IX_STATUS) |->
      (crRdData[0] == statRdData[0] && crRdData[7:6] == statRdData[7:6]));

  assert_pc_even_R9: assert property (@(posedge clk) disable iff (rst)
    (crIndex == IDX_W'(IX_BPC) || crIndex == IDX_W'(IX_BBPC)) |-> !crRdData[0]);

  assert_bbpsw_mask_R8: assert property (@(posedge clk) disable iff (rst)
    crIndex == IDX_W'(IX_BBPSW) |-> (crRdData & ~DATA_W'(BK_MASK)) == '0);

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (rst)
    crIndex > IDX_W'(IX_LAST) |-> crRdData == '0);

  assert_sp_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!crWrEn && !spWrEn) |=> $stable(spOut));

  assert_sp_load_R5: assert property (@(posedge clk) disable iff (rst)
    (spWrEn && !crWrEn) |=> spOut == $past(spWrData));
endmodule

bind ctl_reg_bank ctl_reg_bank_chk #(
  .IX_STATUS(IX_STATUS), .IX_BPC(IX_BPC), .IX_BBPSW(IX_BBPSW), .IX_BBPC(IX_BBPC),
  .IX_LAST(IX_BBPC)
) u_chk (
  .clk(clk), .rst(rst), .crIndex(crIndex), .crWrEn(crWrEn),
  .crRdData(crRdData), .statRdData(statRdData),
  .spWrEn(spWrEn), .spWrData(spWrData), .spOut(spOut)
);

// File: tb/test_ctl_reg_bank.sv
module test_ctl_reg_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  crIndex = '0;
  logic        crWrEn = 1'b0;
  logic [31:0] crWrData = '0;
  logic [31:0] crRdData;
  logic        statWrEn = 1'b0;
  logic [7:0]  statWrData = '0;
  logic [7:0]  statRdData;
  logic        spWrEn = 1'b0;
  logic [31:0] spWrData = '0;
  logic [31:0] spOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    int          src;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  ctl_reg_bank i_ctl_reg_bank (
    .clk(clk), .rst(rst), .crIndex(crIndex), .crWrEn(crWrEn),
    .crWrData(crWrData), .crRdData(crRdData), .statWrEn(statWrEn),
    .statWrData(statWrData), .statRdData(statRdData), .spWrEn(spWrEn),
    .spWrData(spWrData), .spOut(spOut)
  );

  // one cycle of stimulus, applied just after the rising edge
  task automatic drive(input logic we, input logic [3:0] idx, input logic [31:0] wd,
                       input logic bwe = 0, input logic [7:0] bd = 0,
                       input logic swe = 0, input logic [31:0] sd = 0);
    @(posedge clk); #1;
    crWrEn = we; crIndex = idx; crWrData = wd;
    statWrEn = bwe; statWrData = bd;
    spWrEn = swe; spWrData = sd;
  endtask

  // src: 0 control read, 1 byte status read, 2 live SP
  task automatic expect_now(input int src, input logic [31:0] exp, input string req);
    item_t it;
    it.src = src; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string req);
    drive(0, idx, 0);
    expect_now(0, exp, req);
  endtask

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = (it.src == 0) ? crRdData : (it.src == 1) ? {24'h0, statRdData} : spOut;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s src=%0d actual=%h expected=%h", it.req, it.src, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: state after reset
    rd(0, 32'h0, "R1");
    expect_now(1, 32'h0, "R1");
    expect_now(2, 32'h0, "R1");
    rd(6, 32'h0, "R1");

    // R5/R6 set up stack values while stack mode is 0
    drive(0, 0, 0, 0, 0, 1, 32'h0000_1000);
    drive(1, 3, 32'h0000_2000);
    rd(2, 32'h0000_1000, "R6");
    expect_now(2, 32'h0000_1000, "R5");
    rd(3, 32'h0000_2000, "R6");

    // R3/R2/R4: status write, stack mode 0 -> 1
    drive(1, 0, 32'h0000_C5FF);
    rd(0, 32'h0000_C1C1, "R2");
    expect_now(1, 32'hFF, "R3");
    expect_now(2, 32'h0000_2000, "R4");
    rd(2, 32'h0000_1000, "R4");
    rd(3, 32'h0000_2000, "R6");

    // R4: stack mode 1 -> 0
    drive(0, 0, 0, 0, 0, 1, 32'h0000_2222);
    drive(1, 0, 32'h0000_0000);
    rd(0, 32'h0, "R3");
    expect_now(2, 32'h0000_1000, "R4");
    rd(3, 32'h0000_2222, "R4");

    // R5: swap wins over SP port in the same cycle
    drive(1, 0, 32'h0000_0080, 0, 0, 1, 32'h0000_9999);
    rd(0, 32'h0000_0080, "R5");
    expect_now(2, 32'h0000_2222, "R5");
    rd(2, 32'h0000_1000, "R5");

    // R7: condition index
    drive(1, 1, 32'hFFFF_FFFF);
    rd(1, 32'h1, "R7");
    rd(0, 32'h0000_0081, "R7");
    drive(1, 1, 32'h0000_0002);
    rd(1, 32'h0, "R7");
    expect_now(1, 32'h80, "R7");

    // R12: byte port write, no swap
    drive(0, 0, 0, 1, 8'h7F);
    rd(0, 32'h0000_0041, "R12");
    expect_now(1, 32'h7F, "R12");
    expect_now(2, 32'h0000_2222, "R12");

    // R13: control write wins over byte port
    drive(1, 0, 32'h0000_0040, 1, 8'hFF);
    rd(1, 32'h0, "R13");
    expect_now(1, 32'h40, "R13");

    // R6: stack mode 0, index 2 reaches live SP
    drive(1, 2, 32'hAAAA_0000);
    rd(3, 32'h0000_2222, "R6");
    expect_now(2, 32'hAAAA_0000, "R6");

    // R8, R9, R10
    drive(1, 7, 32'hFFFF_FFFF);
    rd(7, 32'h0000_00C1, "R8");
    drive(1, 6, 32'h1234_5677);
    rd(6, 32'h1234_5676, "R9");
    drive(1, 8, 32'hFFFF_FFFF);
    rd(8, 32'hFFFF_FFFE, "R9");
    drive(1, 4, 32'hDEAD_BEEF);
    drive(1, 5, 32'h0BAD_F00D);
    rd(4, 32'hDEAD_BEEF, "R10");
    rd(5, 32'h0BAD_F00D, "R10");

    // R11: unused indices
    drive(1, 9, 32'h5555_5555);
    drive(1, 15, 32'h7777_7777);
    rd(9, 32'h0, "R11");
    rd(15, 32'h0, "R11");
    rd(4, 32'hDEAD_BEEF, "R11");
    rd(0, 32'h0000_0040, "R11");
    expect_now(2, 32'hAAAA_0000, "R11");

    drive(0, 0, 0);
    @(posedge clk);
    @(negedge clk);
    #1;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule